// File: doc/BRIEF.md
# Event Counter Bank with Privilege Filtering

This block holds a set of programmable 64-bit event counters for a processor performance monitor. Each counter has an event-type register that chooses one of 32 single-cycle event pulse lines and carries two privilege filter bits. A counter advances by one on each clock after a pulse of its chosen event. It advances only when all of the following hold: counting is globally enabled, counting is not held off, the current privilege level passes the filter, and the event number is one the bank supports.

Software reaches the bank through a single-cycle register port with four spaces: control, selection, event type and counter. A type or counter slot can be named directly, from a two-bit minor field and a three-bit operation field, or indirectly through the selection register. Type index 31 stands for the filter register of a separate cycle counter. The cycle counter itself lives outside this block, so the bank only drives its clear strobe and filter bits.

Top module: `pmu_evbank`

## Requirements
- R1: A control write keeps only bits 0 (enable), 3, 4 and 5 (hold-off gate) of the written value; a control read returns those bits and zero elsewhere.
- R2: A control write with bit 1 set clears every implemented counter at that clock edge. A control write with bit 2 set raises `cyc_clear` during the access cycle, and only then.
- R3: The direct index is {acc_minor, acc_op2}. When `acc_ind` is set, the index is the selection register, which stores only the low 5 bits of a write and reads back zero-extended.
- R4: Type index 31 reaches the cycle filter, which stores bits 31 and 30 only and drives them on `cyc_filter`. Type slots store bit 31 (P), bit 30 (U) and bits 9:0 (event number), and read zero elsewhere.
- R5: A counter index at or above NCNT, or a type index at or above NCNT other than 31, reads as zero and ignores writes, with no aliasing onto another slot.
- R6: On the clock after a pulse of its event, a counter gains exactly one, wrapping at 2^64. It does so only when control bit 0 is set and counting is not held off. Counting is held off when `count_inhibit` is high and control bit 5 is set.
- R7: With P set, a counter does not count at privilege level 1. With U set, it does not count at level 0. Levels 2 and 3 are not filtered.
- R8: An event number above 31, or one whose bit in SUP_MAP is clear, never counts. The default SUP_MAP is 32'h00FF00FF, so events 0-7 and 16-23 are supported.
- R9: A counter write in the same cycle as a pulse of that counter's event loads the written value, with no increment.
- R10: Changing a slot's event number keeps its count. Later increments come only from the new event.
- R11: After reset every register and counter is zero. Read data is combinational: it reflects the current state during the access cycle and is zero when no read is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_space | input | 2 | 0 control, 1 selection, 2 event type, 3 counter |
| acc_ind | input | 1 | Take the index from the selection register |
| acc_minor | input | 2 | Upper two bits of the direct index |
| acc_op2 | input | 3 | Lower three bits of the direct index |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, same cycle |
| priv_lvl | input | 2 | Current privilege level |
| count_inhibit | input | 1 | Hold-off request, gated by control bit 5 |
| evt_pulse | input | 32 | One pulse line per event number |
| cyc_clear | output | 1 | Clear strobe for the external cycle counter |
| cyc_filter | output | 2 | Cycle filter bits {P, U} |

## Verification
The bench targets index decoding. It writes to slot 8 and checks that slot 0 is unchanged, so a decoder that dropped the minor field would alias onto slot 0. It also reaches index 31 both directly and through a selection written with 0x3F, which exposes a selection that keeps too many bits or a filter that is not mapped. Counting is tested against each gate in turn: an unsupported event, an event number above 31, each privilege bit at its own level, and the hold-off with and without bit 5. A design that ignored any gate would show extra counts. A write that coincides with a pulse, and an event change followed by pulses on the old event, would show up as off-by-one or stray counts if the write priority or the type switch were wrong.

// File: rtl/pmu_evbank_pkg.sv
`timescale 1ns/1ps
package pmu_evbank_pkg;
  typedef enum logic [1:0] {
    SP_CTRL = 2'd0,
    SP_SEL  = 2'd1,
    SP_TYPE = 2'd2,
    SP_CNT  = 2'd3
  } space_e;

  localparam int EVT_W    = 10;
  localparam int IDX_W    = 5;
  localparam int MAX_EVT  = 31;
  localparam int FILT_IDX = 31;
  localparam int CTRL_W   = 6;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 6'h39;
  localparam int CTRL_EN  = 0;
  localparam int CTRL_PCL = 1;
  localparam int CTRL_CCL = 2;
  localparam int CTRL_HLD = 5;

  // true when the privilege filter lets the level through
  function automatic logic priv_allows(input logic p, input logic u,
                                       input logic [1:0] lvl);
    return !((p && lvl == 2'd1) || (u && lvl == 2'd0));
  endfunction

  // true when the event number is in range and marked supported
  function automatic logic evt_known(input logic [EVT_W-1:0] num,
                                     input logic [31:0] map);
    return (num <= EVT_W'(MAX_EVT)) && map[num[4:0]];
  endfunction
endpackage

// File: rtl/pmu_evbank_decode.sv
`timescale 1ns/1ps
module pmu_evbank_decode
  import pmu_evbank_pkg::*;
#(
  parameter int NCNT = 8
) (
  input  logic             ind,
  input  logic [1:0]       minor,
  input  logic [2:0]       op2,
  input  logic [IDX_W-1:0] sel,
  output logic [IDX_W-1:0] idx,
  output logic             in_range,
  output logic             is_filter
);
  localparam logic [IDX_W:0] NCNT_L = (IDX_W+1)'(NCNT);

  assign idx       = ind ? sel : {minor, op2};
  assign in_range  = ({1'b0, idx} < NCNT_L);
  assign is_filter = (idx == IDX_W'(FILT_IDX));
endmodule

// File: rtl/pmu_evbank_slot.sv
`timescale 1ns/1ps
module pmu_evbank_slot
  import pmu_evbank_pkg::*;
#(
  parameter int          CW      = 64,
  parameter logic [31:0] SUP_MAP = 32'h00FF00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cnt,
  input  logic          wr_type,
  input  logic          clr,
  input  logic [63:0]   wdata,
  input  logic          glob_ok,
  input  logic [1:0]    priv_lvl,
  input  logic [31:0]   evt_pulse,
  output logic [CW-1:0] cnt_o,
  output logic [63:0]   type_o,
  output logic          inc_o
);
  logic             p_q, u_q;
  logic [EVT_W-1:0] ev_q;
  logic [CW-1:0]    cnt_q;
  logic             ev_ok, lvl_ok;

  assign ev_ok  = evt_known(ev_q, SUP_MAP);
  assign lvl_ok = priv_allows(p_q, u_q, priv_lvl);
  assign inc_o  = glob_ok && lvl_ok && ev_ok && evt_pulse[ev_q[4:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q   <= 1'b0;
      u_q   <= 1'b0;
      ev_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_type) begin
        p_q  <= wdata[31];
        u_q  <= wdata[30];
        ev_q <= wdata[EVT_W-1:0];
      end
      if (wr_cnt)      cnt_q <= wdata[CW-1:0];
      else if (clr)    cnt_q <= '0;
      else if (inc_o)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign type_o = {32'b0, p_q, u_q, {(30-EVT_W){1'b0}}, ev_q};

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata[CW-1:0]));
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_cnt) |=> cnt_q == '0);
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !clr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  p_unsup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !clr && !wr_type && (ev_q > EVT_W'(MAX_EVT))) |=> $stable(cnt_q));
  p_priv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !clr && p_q && priv_lvl == 2'd1) |=> $stable(cnt_q));
  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_type && !wr_cnt && !clr && !inc_o) |=> $stable(cnt_q));
endmodule

// File: rtl/pmu_evbank.sv
`timescale 1ns/1ps
module pmu_evbank
  import pmu_evbank_pkg::*;
#(
  parameter int          NCNT    = 8,
  parameter int          CW      = 64,
  parameter logic [31:0] SUP_MAP = 32'h00FF00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [1:0]  acc_space,
  input  logic        acc_ind,
  input  logic [1:0]  acc_minor,
  input  logic [2:0]  acc_op2,
  input  logic [63:0] acc_wdata,
  output logic [63:0] acc_rdata,
  input  logic [1:0]  priv_lvl,
  input  logic        count_inhibit,
  input  logic [31:0] evt_pulse,
  output logic        cyc_clear,
  output logic [1:0]  cyc_filter
);
  space_e            space;
  logic [CTRL_W-1:0] ctrl_q;
  logic [IDX_W-1:0]  sel_q;
  logic [1:0]        filt_q;
  logic [IDX_W-1:0]  idx;
  logic              in_range, is_filter;
  logic              wr_ctrl, wr_sel, wr_type_any, wr_cnt_any, rd_any;
  logic              wr_filter, glob_ok, clr_all;
  logic [CW-1:0]     cnt_arr  [NCNT];
  logic [63:0]       type_arr [NCNT];
  logic [NCNT-1:0]   inc_vec;

  assign space       = space_e'(acc_space);
  assign wr_ctrl     = acc_en && acc_wr && space == SP_CTRL;
  assign wr_sel      = acc_en && acc_wr && space == SP_SEL;
  assign wr_type_any = acc_en && acc_wr && space == SP_TYPE;
  assign wr_cnt_any  = acc_en && acc_wr && space == SP_CNT;
  assign rd_any      = acc_en && !acc_wr;
  assign wr_filter   = wr_type_any && is_filter;
  assign clr_all     = wr_ctrl && acc_wdata[CTRL_PCL];
  assign cyc_clear   = wr_ctrl && acc_wdata[CTRL_CCL];
  assign glob_ok     = ctrl_q[CTRL_EN] && !(count_inhibit && ctrl_q[CTRL_HLD]);
  assign cyc_filter  = filt_q;

  pmu_evbank_decode #(.NCNT(NCNT)) u_dec (
    .ind(acc_ind), .minor(acc_minor), .op2(acc_op2), .sel(sel_q),
    .idx(idx), .in_range(in_range), .is_filter(is_filter)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      filt_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q <= acc_wdata[CTRL_W-1:0] & CTRL_KEEP;
      if (wr_sel)    sel_q  <= acc_wdata[IDX_W-1:0];
      if (wr_filter) filt_q <= acc_wdata[31:30];
    end
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_slot
    logic hit;
    assign hit = in_range && idx == IDX_W'(k);
    pmu_evbank_slot #(.CW(CW), .SUP_MAP(SUP_MAP)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_cnt(wr_cnt_any && hit),
      .wr_type(wr_type_any && hit),
      .clr(clr_all),
      .wdata(acc_wdata),
      .glob_ok(glob_ok),
      .priv_lvl(priv_lvl),
      .evt_pulse(evt_pulse),
      .cnt_o(cnt_arr[k]),
      .type_o(type_arr[k]),
      .inc_o(inc_vec[k])
    );
  end

  always_comb begin
    acc_rdata = '0;
    if (rd_any) begin
      unique case (space)
        SP_CTRL: acc_rdata = 64'(ctrl_q);
        SP_SEL:  acc_rdata = 64'(sel_q);
        SP_TYPE: begin
          if (is_filter) acc_rdata = {32'b0, filt_q, 30'b0};
          else for (int k = 0; k < NCNT; k++)
            if (in_range && idx == IDX_W'(k)) acc_rdata = type_arr[k];
        end
        SP_CNT: begin
          for (int k = 0; k < NCNT; k++)
            if (in_range && idx == IDX_W'(k)) acc_rdata = 64'(cnt_arr[k]);
        end
        default: acc_rdata = '0;
      endcase
    end
  end

  p_ctrl_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == ($past(acc_wdata[CTRL_W-1:0]) & 6'h39));
  p_sel_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> sel_q == $past(acc_wdata[4:0]));
  p_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_filter |=> cyc_filter == $past(acc_wdata[31:30]));
  p_oor_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && space == SP_CNT && !in_range) |-> acc_rdata == 64'd0);
  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTRL_EN] |-> inc_vec == '0);
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |-> acc_rdata == 64'd0);
endmodule

// File: tb/test_pmu_evbank.sv
`timescale 1ns/1ps
module test_pmu_evbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_ind = 1'b0;
  logic [1:0]  acc_space = 2'd0, acc_minor = 2'd0, priv_lvl = 2'd0;
  logic [2:0]  acc_op2 = 3'd0;
  logic [63:0] acc_wdata = 64'd0;
  logic [63:0] acc_rdata;
  logic        count_inhibit = 1'b0;
  logic [31:0] evt_pulse = 32'd0;
  logic        cyc_clear;
  logic [1:0]  cyc_filter;

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  event        mon_ev;
  logic        seen_cclr;
  bit          done = 0;

  localparam logic [1:0] CT = 2'd0, SL = 2'd1, TY = 2'd2, CN = 2'd3;

  always #4 clk = ~clk;

  pmu_evbank i_pmu_evbank (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_space(acc_space), .acc_ind(acc_ind), .acc_minor(acc_minor),
    .acc_op2(acc_op2), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .priv_lvl(priv_lvl), .count_inhibit(count_inhibit),
    .evt_pulse(evt_pulse), .cyc_clear(cyc_clear), .cyc_filter(cyc_filter)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data when the driver signals it
  always begin
    @(mon_ev);
    while (exp_q.size() > 0) check(tag_q.pop_front(), acc_rdata, exp_q.pop_front());
  end

  task automatic access(input logic wr, input logic [1:0] sp, input logic ind,
                        input logic [4:0] idx, input logic [63:0] data,
                        input logic [31:0] ev, input logic [63:0] exp,
                        input string tag);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_space = sp; acc_ind = ind;
    acc_minor = idx[4:3]; acc_op2 = idx[2:0]; acc_wdata = data; evt_pulse = ev;
    if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    #2;
    seen_cclr = cyc_clear;
    if (!wr) ->mon_ev;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; evt_pulse = 32'd0; acc_wdata = 64'd0;
  endtask

  task automatic wr_reg(input logic [1:0] sp, input logic ind, input logic [4:0] idx,
                        input logic [63:0] data);
    access(1'b1, sp, ind, idx, data, 32'd0, 64'd0, "");
  endtask

  task automatic rd_reg(input logic [1:0] sp, input logic ind, input logic [4:0] idx,
                        input logic [63:0] exp, input string tag);
    access(1'b0, sp, ind, idx, 64'd0, 32'd0, exp, tag);
  endtask

  task automatic pulse(input logic [31:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_pulse = m;
      @(negedge clk); evt_pulse = 32'd0;
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd_reg(CT, 0, 5'd0, 64'd0, "R11 ctrl after reset");
    rd_reg(CN, 0, 5'd0, 64'd0, "R11 counter0 after reset");
    rd_reg(TY, 0, 5'd0, 64'd0, "R11 type0 after reset");
    @(negedge clk); #2;
    check("R11 idle read data", acc_rdata, 64'd0);
    // R1, R2 control write masking and cycle clear strobe
    wr_reg(CT, 0, 5'd0, {64{1'b1}});
    check("R2 cyc_clear with bit 2", 64'(seen_cclr), 64'd1);
    rd_reg(CT, 0, 5'd0, 64'h39, "R1 ctrl keeps 0x39");
    // R4 type register masking
    wr_reg(TY, 0, 5'd0, 64'hFFFF_FFFF_3FFF_FC03);
    rd_reg(TY, 0, 5'd0, 64'h3, "R4 type field mask");
    // R6 basic counting
    pulse(32'h8, 5);
    rd_reg(CN, 0, 5'd0, 64'd5, "R6 five pulses");
    // R3 indirect access, R8 unsupported event
    wr_reg(SL, 0, 5'd0, 64'hFFFF_FFE1);
    rd_reg(SL, 0, 5'd0, 64'd1, "R3 selection low bits");
    wr_reg(TY, 1, 5'd0, 64'd9);
    rd_reg(TY, 0, 5'd1, 64'd9, "R3 indirect write reaches slot1");
    pulse(32'h208, 4);
    rd_reg(CN, 1, 5'd0, 64'd0, "R8 event 9 unsupported");
    rd_reg(CN, 0, 5'd0, 64'd9, "R8 slot0 keeps counting");
    wr_reg(TY, 0, 5'd2, 64'd40);
    pulse(32'hFFFF_FFFF, 2);
    rd_reg(CN, 0, 5'd2, 64'd0, "R8 event above 31");
    rd_reg(CN, 0, 5'd0, 64'd11, "R6 all-ones pulse counts slot0");
    // R5 out of range, no aliasing
    wr_reg(CN, 0, 5'd8, 64'd123);
    rd_reg(CN, 0, 5'd8, 64'd0, "R5 counter 8 reads zero");
    wr_reg(TY, 0, 5'd8, 64'd5);
    rd_reg(TY, 0, 5'd8, 64'd0, "R5 type 8 reads zero");
    rd_reg(CN, 0, 5'd0, 64'd11, "R5 counter0 untouched");
    rd_reg(TY, 0, 5'd0, 64'd3, "R5 type0 untouched");
    // R4 filter alias at 31
    wr_reg(TY, 0, 5'd31, {64{1'b1}});
    rd_reg(TY, 0, 5'd31, 64'hC000_0000, "R4 filter readback");
    check("R4 cyc_filter pins", 64'(cyc_filter), 64'd3);
    rd_reg(CN, 0, 5'd31, 64'd0, "R5 counter 31 reads zero");
    wr_reg(SL, 0, 5'd0, 64'h3F);
    rd_reg(SL, 0, 5'd0, 64'h1F, "R3 selection keeps 5 bits");
    rd_reg(TY, 1, 5'd0, 64'hC000_0000, "R3 indirect index 31");
    // R7 privilege filter
    wr_reg(TY, 0, 5'd0, 64'h8000_0003);
    priv_lvl = 2'd1; pulse(32'h8, 3);
    rd_reg(CN, 0, 5'd0, 64'd11, "R7 P blocks level 1");
    priv_lvl = 2'd0; pulse(32'h8, 2);
    rd_reg(CN, 0, 5'd0, 64'd13, "R7 P passes level 0");
    wr_reg(TY, 0, 5'd0, 64'h4000_0003);
    pulse(32'h8, 2);
    rd_reg(CN, 0, 5'd0, 64'd13, "R7 U blocks level 0");
    priv_lvl = 2'd2; pulse(32'h8, 1);
    rd_reg(CN, 0, 5'd0, 64'd14, "R7 level 2 unfiltered");
    priv_lvl = 2'd0;
    wr_reg(TY, 0, 5'd0, 64'd3);
    // R6 hold-off and global enable
    count_inhibit = 1'b1; pulse(32'h8, 2);
    rd_reg(CN, 0, 5'd0, 64'd14, "R6 hold-off with bit 5");
    wr_reg(CT, 0, 5'd0, 64'h1);
    check("R2 no cyc_clear without bit 2", 64'(seen_cclr), 64'd0);
    pulse(32'h8, 1);
    rd_reg(CN, 0, 5'd0, 64'd15, "R6 inhibit ignored without bit 5");
    count_inhibit = 1'b0;
    wr_reg(CT, 0, 5'd0, 64'h0);
    pulse(32'h8, 1);
    rd_reg(CN, 0, 5'd0, 64'd15, "R6 disabled holds");
    wr_reg(CT, 0, 5'd0, 64'h1);
    // R9 write beats increment
    access(1'b1, CN, 0, 5'd0, 64'd100, 32'h8, 64'd0, "");
    rd_reg(CN, 0, 5'd0, 64'd100, "R9 write over pulse");
    pulse(32'h8, 1);
    rd_reg(CN, 0, 5'd0, 64'd101, "R9 counting resumes");
    // R10 event change
    wr_reg(TY, 0, 5'd0, 64'd5);
    rd_reg(CN, 0, 5'd0, 64'd101, "R10 value kept");
    pulse(32'h8, 2);
    rd_reg(CN, 0, 5'd0, 64'd101, "R10 old event ignored");
    pulse(32'h20, 3);
    rd_reg(CN, 0, 5'd0, 64'd104, "R10 new event counts");
    // R2 counter clear
    wr_reg(CN, 0, 5'd1, 64'd77);
    rd_reg(CN, 0, 5'd1, 64'd77, "R2 slot1 loaded");
    wr_reg(CT, 0, 5'd0, 64'h3);
    rd_reg(CN, 0, 5'd0, 64'd0, "R2 slot0 cleared");
    rd_reg(CN, 0, 5'd1, 64'd0, "R2 slot1 cleared");
    rd_reg(CT, 0, 5'd0, 64'd1, "R1 clear bits not stored");
    // R6 wrap
    wr_reg(CN, 0, 5'd0, {64{1'b1}});
    pulse(32'h20, 1);
    rd_reg(CN, 0, 5'd0, 64'd0, "R6 wrap at 2^64");
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule